// File: doc/BRIEF.md
# Dual-NFSR Keystream Generator with Initialization Sequencer

This block produces a bit-serial keystream from a 121-bit secret state held in two nonlinear feedback shift registers: a short 31-cell register and a long 90-cell register. Both shift toward cell 0, and each takes its new bit into its top cell. The long register's feedback is masked by the lowest cell of the short register. A nonlinear output function reads taps from both registers and yields one bit per clock.

A one-cycle `start` pulse latches the state from a 120-bit key and a 64-bit IV. The sequencer then runs an initialization that cannot be skipped. First come 128 mixing clocks, where the output bit is folded into both feedbacks and nothing is emitted. Next, in a single step without a shift, the key is XORed into the whole state a second time. Last come 128 diffusion clocks in normal mode, whose output bits are thrown away. After that the block emits one keystream bit per clock with `ks_valid` high, up to a fixed number of bits per key/IV pair.

The key has to stay steady on its input from the `start` pulse until the second key addition is done, because the block does not store it. A new `start` at any time abandons the current run and reloads the state.

Top module: `keystream_gen`

## Requirements
- R1: After a synchronous reset, `ks_valid`, `ks_bit` and `busy` are 0 and stay 0 until a `start` pulse.
- R2: On the clock edge where `start` is sampled high, the state is loaded. From the next cycle `busy` is 1 through the mixing, key-add and diffusion steps, 257 clocks in all. `busy` falls one cycle before the first keystream bit. `ks_valid` first reads 1 after the 258th edge counted from the loading edge, and never while `busy` is 1.
- R3: The load maps the state as follows. Long cell j takes key[j] XOR iv[j] for j below 64 and key[j] for j from 64 to 89. Short cell i takes key[i+90] for i below 29. Short cell 29 takes the inverse of key[119]. Short cell 30 takes 1.
- R4: For 128 clocks the output bit is XORed into both feedback values, and both registers shift.
- R5: The second key addition is one step without a shift. Long cell j is XORed with key[j]. Short cells 0 to 29 are XORed with key[90..119], with no inversion. Short cell 30 is forced to 1.
- R6: After 128 discarded clocks in normal mode, the bits emitted with `ks_valid` equal the output function of the state in order, one per clock. They match an independent model for any key/IV pair.
- R7: Once started, the keystream has no gaps: `ks_valid` stays 1 on every clock until the limit is reached.
- R8: Exactly 2^LIMIT_LOG2 bits are emitted per key/IV pair. After that, `ks_valid` and `busy` stay 0 until the next `start`.
- R9: A `start` pulse during initialization restarts it. The timing and the keystream then follow the new key/IV alone.
- R10: A `start` pulse during keystream output drops `ks_valid` on the following cycle and starts a fresh initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: load key/IV and begin initialization |
| key | input | 120 | Secret key, held steady until the key addition |
| iv | input | 64 | Public initialization vector |
| ks_bit | output | 1 | Keystream bit, meaningful while ks_valid is 1 |
| ks_valid | output | 1 | Keystream bit valid this cycle |
| busy | output | 1 | Initialization in progress |

## Verification
The generator is run with an all-zero key and IV, with all ones, and with a mixed hex pattern. It is also run with two keys that differ only in bit 119 and two IVs that differ in a single bit. The zero and all-ones cases expose stuck or missing feedback terms. The bit-119 pair separates the inverted load of that bit from its plain second addition. The single IV bit shows that the IV enters only the low long cells. The bench configures a small output limit so that the end of the stream and the silence after it can be checked in full. Restarts both during initialization and during output confirm that no state from the old run leaks into the new one.

// File: rtl/keystream_gen_pkg.sv
package keystream_gen_pkg;
  localparam int S_LEN = 31;
  localparam int B_LEN = 90;
  localparam int KEY_W = 120;
  localparam int IV_W  = 64;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_MIX,
    PH_ADD,
    PH_DIFF,
    PH_GEN,
    PH_DONE
  } phase_e;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_LOAD,
    OP_MIX,
    OP_ADD,
    OP_STEP
  } reg_op_e;
endpackage

// File: rtl/kg_short_reg.sv
module kg_short_reg
  import keystream_gen_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  reg_op_e             op,
  input  logic [KEY_W-1:0]    key,
  input  logic                z,
  output logic [S_LEN-1:0]    s
);
  localparam int KOFF = B_LEN;

  logic fb;

  always_comb begin
    fb = s[0] ^ s[2] ^ s[5] ^ s[6] ^ s[15] ^ s[17] ^ s[18] ^ s[20] ^ s[25]
       ^ (s[8] & s[18]) ^ (s[8] & s[20]) ^ (s[12] & s[21])
       ^ (s[14] & s[19]) ^ (s[17] & s[21]) ^ (s[20] & s[22])
       ^ (s[4] & s[12] & s[22]) ^ (s[4] & s[19] & s[22])
       ^ (s[7] & s[20] & s[21]) ^ (s[8] & s[18] & s[22])
       ^ (s[8] & s[20] & s[22]) ^ (s[12] & s[19] & s[22])
       ^ (s[20] & s[21] & s[22])
       ^ (s[4] & s[7] & s[12] & s[21]) ^ (s[4] & s[7] & s[19] & s[21])
       ^ (s[4] & s[12] & s[21] & s[22]) ^ (s[4] & s[19] & s[21] & s[22])
       ^ (s[7] & s[8] & s[18] & s[21]) ^ (s[7] & s[8] & s[20] & s[21])
       ^ (s[7] & s[12] & s[19] & s[21]) ^ (s[8] & s[18] & s[21] & s[22])
       ^ (s[8] & s[20] & s[21] & s[22]) ^ (s[12] & s[19] & s[21] & s[22]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s <= '0;
    end else begin
      unique case (op)
        OP_LOAD: s <= {1'b1, ~key[KEY_W-1], key[KEY_W-2:KOFF]};
        OP_MIX:  s <= {fb ^ z, s[S_LEN-1:1]};
        OP_ADD:  s <= {1'b1, s[S_LEN-2:0] ^ key[KEY_W-1:KOFF]};
        OP_STEP: s <= {fb, s[S_LEN-1:1]};
        default: s <= s;
      endcase
    end
  end
endmodule

// File: rtl/kg_long_reg.sv
module kg_long_reg
  import keystream_gen_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  reg_op_e             op,
  input  logic [KEY_W-1:0]    key,
  input  logic [IV_W-1:0]     iv,
  input  logic                z,
  input  logic                mask,
  output logic [B_LEN-1:0]    b
);
  logic [B_LEN-1:0] load_val;
  logic             fb;

  genvar j;
  generate
    for (j = 0; j < B_LEN; j++) begin : g_load
      if (j < IV_W) begin : g_mixed
        assign load_val[j] = key[j] ^ iv[j];
      end else begin : g_plain
        assign load_val[j] = key[j];
      end
    end
  endgenerate

  always_comb begin
    fb = mask ^ b[0] ^ b[24] ^ b[49] ^ b[79] ^ b[84]
       ^ (b[3] & b[59]) ^ (b[10] & b[12]) ^ (b[15] & b[16])
       ^ (b[25] & b[53]) ^ (b[35] & b[42]) ^ (b[55] & b[58])
       ^ (b[60] & b[74])
       ^ (b[20] & b[22] & b[23]) ^ (b[62] & b[68] & b[72])
       ^ (b[77] & b[80] & b[81] & b[83]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b <= '0;
    end else begin
      unique case (op)
        OP_LOAD: b <= load_val;
        OP_MIX:  b <= {fb ^ z, b[B_LEN-1:1]};
        OP_ADD:  b <= b ^ key[B_LEN-1:0];
        OP_STEP: b <= {fb, b[B_LEN-1:1]};
        default: b <= b;
      endcase
    end
  end
endmodule

// File: rtl/kg_out_fn.sv
module kg_out_fn
  import keystream_gen_pkg::*;
(
  input  logic [S_LEN-1:0] s,
  input  logic [B_LEN-1:0] b,
  output logic             z
);
  logic lin, quad, hi, mixd;

  always_comb begin
    lin  = b[7] ^ b[11] ^ b[30] ^ b[40] ^ b[45] ^ b[54] ^ b[71];
    quad = (b[4] & b[21]) ^ (b[9] & b[52]) ^ (b[18] & b[37]) ^ (b[44] & b[76]);
    hi   = b[5] ^ (b[8] & b[82]) ^ (b[34] & b[67] & b[73])
         ^ (b[2] & b[28] & b[41] & b[65])
         ^ (b[13] & b[29] & b[50] & b[64] & b[75])
         ^ (b[6] & b[14] & b[26] & b[32] & b[47] & b[61])
         ^ (b[1] & b[19] & b[27] & b[43] & b[57] & b[66] & b[78]);
    mixd = s[23] ^ (s[3] & s[16]) ^ (s[9] & s[13] & b[48])
         ^ (s[1] & s[24] & b[38] & b[63]);
    z    = lin ^ quad ^ hi ^ mixd;
  end
endmodule

// File: rtl/kg_sequencer.sv
module kg_sequencer
  import keystream_gen_pkg::*;
#(
  parameter int MIX_CLOCKS  = 128,
  parameter int DIFF_CLOCKS = 128,
  parameter int LIMIT_LOG2  = 18
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  output reg_op_e op,
  output logic    emit,
  output logic    busy
);
  localparam int MAXC = (MIX_CLOCKS > DIFF_CLOCKS) ? MIX_CLOCKS : DIFF_CLOCKS;
  localparam int CW   = $clog2(MAXC) + 1;
  localparam int OW   = LIMIT_LOG2 + 1;
  localparam logic [OW-1:0] OUT_LAST  = OW'((64'd1 << LIMIT_LOG2) - 64'd1);
  localparam logic [CW-1:0] MIX_LAST  = CW'(MIX_CLOCKS - 1);
  localparam logic [CW-1:0] DIFF_LAST = CW'(DIFF_CLOCKS - 1);

  phase_e          phase;
  logic [CW-1:0]   cnt;
  logic [OW-1:0]   ocnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      ocnt  <= '0;
    end else if (start) begin
      phase <= PH_MIX;
      cnt   <= '0;
      ocnt  <= '0;
    end else begin
      unique case (phase)
        PH_MIX: begin
          if (cnt == MIX_LAST) begin
            phase <= PH_ADD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ADD: phase <= PH_DIFF;
        PH_DIFF: begin
          if (cnt == DIFF_LAST) begin
            phase <= PH_GEN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_GEN: begin
          ocnt <= ocnt + 1'b1;
          if (ocnt == OUT_LAST) phase <= PH_DONE;
        end
        default: phase <= phase;
      endcase
    end
  end

  always_comb begin
    if (start) begin
      op = OP_LOAD;
    end else begin
      unique case (phase)
        PH_MIX:  op = OP_MIX;
        PH_ADD:  op = OP_ADD;
        PH_DIFF: op = OP_STEP;
        PH_GEN:  op = OP_STEP;
        default: op = OP_HOLD;
      endcase
    end
    emit = (phase == PH_GEN) && !start;
    busy = (phase == PH_MIX) || (phase == PH_ADD) || (phase == PH_DIFF);
  end
endmodule

// File: rtl/keystream_gen.sv
module keystream_gen
  import keystream_gen_pkg::*;
#(
  parameter int MIX_CLOCKS  = 128,
  parameter int DIFF_CLOCKS = 128,
  parameter int LIMIT_LOG2  = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [119:0] key,
  input  logic [63:0]  iv,
  output logic         ks_bit,
  output logic         ks_valid,
  output logic         busy
);
  reg_op_e          op;
  logic             emit;
  logic             z;
  logic [S_LEN-1:0] s_st;
  logic [B_LEN-1:0] b_st;

  kg_sequencer #(
    .MIX_CLOCKS (MIX_CLOCKS),
    .DIFF_CLOCKS(DIFF_CLOCKS),
    .LIMIT_LOG2 (LIMIT_LOG2)
  ) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .op   (op),
    .emit (emit),
    .busy (busy)
  );

  kg_short_reg u_sreg (
    .clk(clk), .rst(rst), .op(op), .key(key), .z(z), .s(s_st)
  );

  kg_long_reg u_breg (
    .clk(clk), .rst(rst), .op(op), .key(key), .iv(iv), .z(z),
    .mask(s_st[0]), .b(b_st)
  );

  kg_out_fn u_out (
    .s(s_st), .b(b_st), .z(z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ks_valid <= 1'b0;
      ks_bit   <= 1'b0;
    end else begin
      ks_valid <= emit;
      ks_bit   <= emit ? z : 1'b0;
    end
  end
endmodule

// File: rtl/keystream_gen_chk.sv
module keystream_gen_chk #(
  parameter int LIMIT_LOG2 = 18
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic ks_valid,
  input logic busy
);
  localparam int VW = LIMIT_LOG2 + 1;
  localparam logic [VW-1:0] LIMIT = VW'(64'd1 << LIMIT_LOG2);

  logic [VW-1:0] vcnt;

  always_ff @(posedge clk) begin
    if (rst || start) vcnt <= '0;
    else if (ks_valid) vcnt <= vcnt + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!ks_valid && !busy));

  // R2
  valid_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ks_valid |-> !busy);

  // R2
  busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R10
  start_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !ks_valid);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ks_valid |-> (vcnt < LIMIT));
endmodule

bind keystream_gen keystream_gen_chk #(.LIMIT_LOG2(LIMIT_LOG2)) u_chk (
  .clk(clk), .rst(rst), .start(start), .ks_valid(ks_valid), .busy(busy)
);

// File: tb/keystream_gen_test.sv
module keystream_gen_test;
  localparam int LOG2 = 6;
  localparam int NB   = 1 << LOG2;
  localparam int LAT  = 258;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [119:0] key = '0;
  logic [63:0]  iv = '0;
  logic         ks_bit, ks_valid, busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  keystream_gen #(.LIMIT_LOG2(LOG2)) uut (
    .clk(clk), .rst(rst), .start(start), .key(key), .iv(iv),
    .ks_bit(ks_bit), .ks_valid(ks_valid), .busy(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 60000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic bit rz(bit [30:0] s, bit [89:0] b);
    bit l, q, t, u;
    l = b[7]^b[11]^b[30]^b[40]^b[45]^b[54]^b[71];
    q = (b[4]&b[21])^(b[9]&b[52])^(b[18]&b[37])^(b[44]&b[76]);
    t = b[5]^(b[8]&b[82])^(b[34]&b[67]&b[73])^(b[2]&b[28]&b[41]&b[65])
      ^(b[13]&b[29]&b[50]&b[64]&b[75])^(b[6]&b[14]&b[26]&b[32]&b[47]&b[61])
      ^(b[1]&b[19]&b[27]&b[43]&b[57]&b[66]&b[78]);
    u = s[23]^(s[3]&s[16])^(s[9]&s[13]&b[48])^(s[1]&s[24]&b[38]&b[63]);
    return l^q^t^u;
  endfunction

  function automatic bit rfs(bit [30:0] s);
    return s[0]^s[2]^s[5]^s[6]^s[15]^s[17]^s[18]^s[20]^s[25]
      ^(s[8]&s[18])^(s[8]&s[20])^(s[12]&s[21])^(s[14]&s[19])^(s[17]&s[21])^(s[20]&s[22])
      ^(s[4]&s[12]&s[22])^(s[4]&s[19]&s[22])^(s[7]&s[20]&s[21])^(s[8]&s[18]&s[22])
      ^(s[8]&s[20]&s[22])^(s[12]&s[19]&s[22])^(s[20]&s[21]&s[22])
      ^(s[4]&s[7]&s[12]&s[21])^(s[4]&s[7]&s[19]&s[21])^(s[4]&s[12]&s[21]&s[22])
      ^(s[4]&s[19]&s[21]&s[22])^(s[7]&s[8]&s[18]&s[21])^(s[7]&s[8]&s[20]&s[21])
      ^(s[7]&s[12]&s[19]&s[21])^(s[8]&s[18]&s[21]&s[22])^(s[8]&s[20]&s[21]&s[22])
      ^(s[12]&s[19]&s[21]&s[22]);
  endfunction

  function automatic bit rfb(bit [30:0] s, bit [89:0] b);
    return s[0]^b[0]^b[24]^b[49]^b[79]^b[84]^(b[3]&b[59])^(b[10]&b[12])
      ^(b[15]&b[16])^(b[25]&b[53])^(b[35]&b[42])^(b[55]&b[58])^(b[60]&b[74])
      ^(b[20]&b[22]&b[23])^(b[62]&b[68]&b[72])^(b[77]&b[80]&b[81]&b[83]);
  endfunction

  // Reference model following R3..R6.
  function automatic bit [NB-1:0] ref_stream(bit [119:0] k, bit [63:0] v);
    bit [30:0] s;
    bit [89:0] b;
    bit [NB-1:0] out;
    bit zz, ns, nb;
    for (int j = 0; j < 90; j++) b[j] = (j < 64) ? (k[j] ^ v[j]) : k[j];
    for (int i = 0; i < 29; i++) s[i] = k[i+90];
    s[29] = ~k[119];
    s[30] = 1'b1;
    for (int n = 0; n < 128; n++) begin
      zz = rz(s, b); ns = rfs(s) ^ zz; nb = rfb(s, b) ^ zz;
      s = {ns, s[30:1]}; b = {nb, b[89:1]};
    end
    for (int j = 0; j < 90; j++) b[j] = b[j] ^ k[j];
    for (int i = 0; i < 30; i++) s[i] = s[i] ^ k[i+90];
    s[30] = 1'b1;
    for (int n = 0; n < 128; n++) begin
      ns = rfs(s); nb = rfb(s, b);
      s = {ns, s[30:1]}; b = {nb, b[89:1]};
    end
    for (int n = 0; n < NB; n++) begin
      out[n] = rz(s, b); ns = rfs(s); nb = rfb(s, b);
      s = {ns, s[30:1]}; b = {nb, b[89:1]};
    end
    return out;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic kick(logic [119:0] k, logic [63:0] v);
    @(negedge clk);
    key = k; iv = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // R2: latency and busy window after the loading edge
  task automatic wait_first;
    int n = 0;
    bit busy_ok = 1'b1;
    bit busy_low_ok = 1'b1;
    while (!ks_valid && n < 400) begin
      if (n < 257 && !busy) busy_ok = 1'b0;
      if (n >= 257 && busy) busy_low_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(n == LAT, "R2 first valid cycle", n, LAT);
    chk(busy_ok, "R2 busy high during init", 0, 1);
    chk(busy_low_ok, "R2 busy low before output", 1, 0);
  endtask

  // R6/R7/R8: compare stream from bit index first, then check silence
  task automatic read_stream(bit [NB-1:0] exp, int first, string tag);
    int bad = 0;
    bit gap = 1'b0;
    for (int i = first; i < NB; i++) begin
      if (!ks_valid) gap = 1'b1;
      if (ks_bit !== exp[i]) begin
        bad++;
        if (bad == 1)
          $display("FAIL R6 %s bit %0d: actual %0d expected %0d", tag, i, ks_bit, exp[i]);
      end
      @(negedge clk);
    end
    checks = checks + 1;
    if (bad != 0) errors = errors + 1;
    chk(!gap, "R7 contiguous valid", 0, 1);
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 8; i++) begin
        if (ks_valid || busy) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R8 silent after limit", 0, 1);
    end
  endtask

  task automatic run_vec(logic [119:0] k, logic [63:0] v, string tag);
    bit [NB-1:0] e;
    e = ref_stream(k, v);
    kick(k, v);
    wait_first();
    read_stream(e, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1
    chk(!ks_valid && !busy && !ks_bit, "R1 idle after reset",
        int'({ks_valid, busy, ks_bit}), 0);

    // R3 R4 R5 R6 with distinct patterns
    run_vec('0, '0, "zero");
    run_vec({120{1'b1}}, {64{1'b1}}, "ones");
    run_vec(120'h0123456789ABCDEF0123456789ABCD, 64'hFEDCBA9876543210, "mixed");
    run_vec(120'h8123456789ABCDEF0123456789ABCD, 64'hFEDCBA9876543210, "R3 key119 flipped");
    run_vec(120'h0123456789ABCDEF0123456789ABCD, 64'hFEDCBA9876543211, "R3 iv bit0 flipped");
    run_vec(120'hA5A5A5A5A5A5A5A5A5A5A5A5A5A5A5, 64'h0, "R5 key only");

    // R9: restart during initialization
    begin
      bit [NB-1:0] e;
      kick(120'h111111111111111111111111111111, 64'h2222222222222222);
      repeat (100) @(negedge clk);
      e = ref_stream(120'h3C3C3C3C3C3C3C3C3C3C3C3C3C3C3C, 64'h0F0F0F0F0F0F0F0F);
      kick(120'h3C3C3C3C3C3C3C3C3C3C3C3C3C3C3C, 64'h0F0F0F0F0F0F0F0F);
      wait_first();
      read_stream(e, 0, "R9 restart in init");
    end

    // R10: restart during output
    begin
      bit [NB-1:0] e;
      kick(120'h0F1E2D3C4B5A69788796A5B4C3D2E1, 64'h1357913579135791);
      wait_first();
      repeat (10) @(negedge clk);
      e = ref_stream(120'hFFFF0000FFFF0000FFFF0000FFFF00, 64'hDEADBEEF00C0FFEE);
      kick(120'hFFFF0000FFFF0000FFFF0000FFFF00, 64'hDEADBEEF00C0FFEE);
      chk(!ks_valid, "R10 valid dropped after start", int'(ks_valid), 0);
      chk(busy, "R10 busy after start", int'(busy), 1);
      wait_first();
      read_stream(e, 0, "R10 restart in output");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule